// File: doc/BRIEF.md
# Big-Endian Sized Memory Port

This block is a load/store front end for a small on-chip RAM that holds 2^P bytes, P being a parameter. A requester presents an address, an access size (byte, word or longword), a write enable, write data and a signed-read select, all qualified by a request strobe. Writes are committed on the rising clock edge. Reads return data one cycle later, widened to 32 bits.

Bytes are ordered big-endian. The most significant byte of a longword or a word sits at the lowest address. Addresses never fault. Bits above the array size are discarded, so the space wraps. The low bits that a wider access cannot use are cleared before the array is indexed. A flag, registered with the read data, reports when the clearing changed the address.

Internally the array is split into four byte lanes, one per address offset within a longword. An alignment stage produces a row index, an aligned lane offset and the misalignment flag. A write-steering stage chooses the lanes to enable and the byte each lane receives. An extraction stage rebuilds the read result from the four registered lane bytes and the registered size, offset and sign select. Because this is a datapath with no sequencing, there is no state machine. The access size is the only enumerated type: ACC_BYTE, ACC_WORD, ACC_LONG and ACC_LONG_ALT.

Top module: `bemem_port`

## Requirements
- R1: Only the low P address bits select a byte (P = 12 by default). An access at A + k·2^P reaches the same byte as an access at A, for any integer k.
- R2: A word access clears address bit 0, and a longword access clears address bits 1:0, before the array is indexed. A byte access uses the address unchanged.
- R3: A longword at aligned address A is stored with bits 31:24 at A, 23:16 at A+1, 15:8 at A+2 and 7:0 at A+3. A longword read returns the same packing.
- R4: A word at aligned address A is stored with bits 15:8 at A and bits 7:0 at A+1.
- R5: A byte read with sign_ext = 1 returns the byte sign-extended from its bit 7. With sign_ext = 0 it returns the byte zero-extended.
- R6: A word read with sign_ext = 1 returns the word sign-extended from its bit 15. With sign_ext = 0 it returns the word zero-extended.
- R7: A byte write changes only the addressed byte. A word write changes only its two bytes. All other bytes of the array keep their values.
- R8: One cycle after a request, misalign is 1 exactly when the masking of R2 cleared a nonzero bit of that request's address. A byte access never sets it. A misaligned access still completes at the aligned address.
- R9: Read data appears on rdata one cycle after a read request. It then holds its value through idle cycles and write requests until the next read request.
- R10: The size field encodes byte as 0, word as 1 and longword as 2. The value 3 behaves as a longword. A longword read ignores sign_ext.
- R11: While rst_n is low, and after reset until the first request, rdata is 0 and misalign is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes on the rising edge. |
| rst_n | input | 1 | Asynchronous active-low reset for the read and flag registers. |
| req_valid | input | 1 | The access presented this cycle is performed. |
| wr_en | input | 1 | 1 for a write, 0 for a read. |
| size | input | 2 | Access size: 0 byte, 1 word, 2 or 3 longword. |
| sign_ext | input | 1 | Selects sign extension for byte and word reads. |
| addr | input | 32 | Byte address, before wrapping and alignment. |
| wdata | input | 32 | Write data, right-justified for byte and word writes. |
| rdata | output | 32 | Read result of the most recent read request. |
| misalign | output | 1 | Alignment flag for the most recent request. |

## Verification
Both rdata and misalign are due exactly one rising edge after the request that produces them. The bench applies every request just after a falling edge, drops the strobe at the next falling edge, and samples both outputs at that same moment. That moment falls half a period after the capturing edge and half a period before the next one. To show that write requests leave rdata untouched, the bench samples rdata after the write and again after idle cycles. It then issues one more read and checks that the new value arrives with the same one-cycle latency.

// File: rtl/bemem_pkg.sv
`timescale 1ns/1ps
package bemem_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE     = 2'd0,
        ACC_WORD     = 2'd1,
        ACC_LONG     = 2'd2,
        ACC_LONG_ALT = 2'd3
    } acc_size_e;

    localparam int LANES     = 4;
    localparam int LANE_BITS = 2;
endpackage

// File: rtl/bemem_align.sv
`timescale 1ns/1ps
// Wraps the address into the array and forces natural alignment per size.
module bemem_align
    import bemem_pkg::*;
#(
    parameter int P = 12
) (
    input  acc_size_e           size,
    input  logic [31:0]         addr,
    output logic [P-LANE_BITS-1:0] row,
    output logic [LANE_BITS-1:0]   off,
    output logic                misalign
);
    logic unused_hi;
    assign unused_hi = ^addr[31:P];

    assign row = addr[P-1:LANE_BITS];

    always_comb begin
        unique case (size)
            ACC_BYTE: begin
                off      = addr[1:0];
                misalign = 1'b0;
            end
            ACC_WORD: begin
                off      = {addr[1], 1'b0};
                misalign = addr[0];
            end
            ACC_LONG, ACC_LONG_ALT: begin
                off      = 2'b00;
                misalign = |addr[1:0];
            end
        endcase
    end
endmodule

// File: rtl/bemem_steer.sv
`timescale 1ns/1ps
// Chooses the lanes a write touches and the byte each lane receives.
// Lane i holds the byte whose address offset inside a longword is i.
module bemem_steer
    import bemem_pkg::*;
(
    input  acc_size_e                 size,
    input  logic [LANE_BITS-1:0]      off,
    input  logic [31:0]               wdata,
    output logic [LANES-1:0]          lane_en,
    output logic [8*LANES-1:0]        lane_data
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam logic [LANE_BITS-1:0] LI = LANE_BITS'(gi);
        logic       en_l;
        logic [7:0] b_l;

        always_comb begin
            unique case (size)
                ACC_BYTE: begin
                    en_l = (off == LI);
                    b_l  = wdata[7:0];
                end
                ACC_WORD: begin
                    en_l = (off[1] == LI[1]);
                    b_l  = LI[0] ? wdata[7:0] : wdata[15:8];
                end
                ACC_LONG, ACC_LONG_ALT: begin
                    en_l = 1'b1;
                    b_l  = wdata[31-8*gi -: 8];
                end
            endcase
        end

        assign lane_en[gi]           = en_l;
        assign lane_data[8*gi +: 8]  = b_l;
    end
endmodule

// File: rtl/bemem_bank.sv
`timescale 1ns/1ps
// One byte lane: storage plus a registered read port.
module bemem_bank #(
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                rd_en,
    input  logic [ROW_BITS-1:0] row,
    input  logic [7:0]          wbyte,
    output logic [7:0]          rbyte_q
);
    localparam int DEPTH = 1 << ROW_BITS;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbyte_q <= 8'h00;
        end else if (rd_en) begin
            rbyte_q <= mem[row];
        end
    end
endmodule

// File: rtl/bemem_extract.sv
`timescale 1ns/1ps
// Rebuilds a big-endian result from the registered lanes and extends it.
module bemem_extract
    import bemem_pkg::*;
(
    input  acc_size_e            size,
    input  logic [LANE_BITS-1:0] off,
    input  logic                 sign_ext,
    input  logic [8*LANES-1:0]   lanes,
    output logic [31:0]          rdata
);
    logic [7:0]  sel_byte;
    logic [15:0] sel_word;
    logic [31:0] sel_long;

    assign sel_byte = lanes[8*off +: 8];
    assign sel_word = off[1] ? {lanes[23:16], lanes[31:24]}
                             : {lanes[7:0],   lanes[15:8]};
    assign sel_long = {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]};

    always_comb begin
        unique case (size)
            ACC_BYTE:
                rdata = {{24{sign_ext & sel_byte[7]}}, sel_byte};
            ACC_WORD:
                rdata = {{16{sign_ext & sel_word[15]}}, sel_word};
            ACC_LONG, ACC_LONG_ALT:
                rdata = sel_long;
        endcase
    end
endmodule

// File: rtl/bemem_port.sv
`timescale 1ns/1ps
module bemem_port
    import bemem_pkg::*;
#(
    parameter int P = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        wr_en,
    input  logic [1:0]  size,
    input  logic        sign_ext,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        misalign
);
    localparam int ROW_BITS = P - LANE_BITS;

    acc_size_e                size_e;
    logic [ROW_BITS-1:0]      row;
    logic [LANE_BITS-1:0]     off;
    logic                     mis_c;
    logic [LANES-1:0]         lane_en;
    logic [8*LANES-1:0]       lane_data;
    logic [8*LANES-1:0]       lane_q;
    logic                     do_write;
    logic                     do_read;

    acc_size_e                size_q;
    logic [LANE_BITS-1:0]     off_q;
    logic                     sign_q;
    logic                     mis_q;

    assign size_e   = acc_size_e'(size);
    assign do_write = req_valid & wr_en;
    assign do_read  = req_valid & ~wr_en;

    bemem_align #(.P(P)) u_align (
        .size     (size_e),
        .addr     (addr),
        .row      (row),
        .off      (off),
        .misalign (mis_c)
    );

    bemem_steer u_steer (
        .size      (size_e),
        .off       (off),
        .wdata     (wdata),
        .lane_en   (lane_en),
        .lane_data (lane_data)
    );

    // Lane counts per write size, next to the steering they guard.
    assert_byte_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && size_e == ACC_BYTE) |-> $countones(lane_en) == 1);
    assert_word_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && size_e == ACC_WORD) |-> $countones(lane_en) == 2);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_bank
        bemem_bank #(.ROW_BITS(ROW_BITS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (do_write & lane_en[gi]),
            .rd_en   (do_read),
            .row     (row),
            .wbyte   (lane_data[8*gi +: 8]),
            .rbyte_q (lane_q[8*gi +: 8])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= ACC_BYTE;
            off_q  <= '0;
            sign_q <= 1'b0;
        end else if (do_read) begin
            size_q <= size_e;
            off_q  <= off;
            sign_q <= sign_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mis_q <= 1'b0;
        end else if (req_valid) begin
            mis_q <= mis_c;
        end
    end

    assign misalign = mis_q;

    assert_byte_never_mis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size_e == ACC_BYTE) |=> !misalign);

    bemem_extract u_extract (
        .size     (size_q),
        .off      (off_q),
        .sign_ext (sign_q),
        .lanes    (lane_q),
        .rdata    (rdata)
    );

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !do_read |=> $stable(rdata));
    assert_byte_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == ACC_BYTE && sign_q) |-> rdata[31:8] == {24{rdata[7]}});
    assert_byte_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == ACC_BYTE && !sign_q) |-> rdata[31:8] == 24'h0);
    assert_word_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == ACC_WORD && sign_q) |-> rdata[31:16] == {16{rdata[15]}});
    assert_word_zext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == ACC_WORD && !sign_q) |-> rdata[31:16] == 16'h0);
endmodule

// File: tb/test_bemem_port.sv
`timescale 1ns/1ps
module test_bemem_port;
    localparam int P    = 12;
    localparam int MSZ  = 1 << P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  size = 2'd0;
    logic        sign_ext = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        misalign;

    int checks   = 0;
    int failures = 0;

    logic [7:0] model [MSZ];

    always #2.5 clk = ~clk;

    bemem_port #(.P(P)) i_bemem_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .wr_en(wr_en),
        .size(size), .sign_ext(sign_ext), .addr(addr), .wdata(wdata),
        .rdata(rdata), .misalign(misalign)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected index per the wrap and alignment requirements (R1, R2).
    function automatic int base_of(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] m;
        m = a & (MSZ - 1);
        if (sz == 2'd1)      m[0] = 1'b0;
        else if (sz != 2'd0) m[1:0] = 2'b00;
        return int'(m);
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] sz, input logic sg);
        int b;
        b = base_of(a, sz);
        if (sz == 2'd0)
            return {{24{sg & model[b][7]}}, model[b]};
        else if (sz == 2'd1)
            return {{16{sg & model[b][7]}}, model[b], model[b+1]};
        else
            return {model[b], model[b+1], model[b+2], model[b+3]};
    endfunction

    function automatic logic exp_mis(input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return a[0];
        return |a[1:0];
    endfunction

    task automatic do_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        int b;
        @(negedge clk);
        req_valid = 1'b1; wr_en = 1'b1; size = sz; addr = a; wdata = d; sign_ext = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        b = base_of(a, sz);
        if (sz == 2'd0) model[b] = d[7:0];
        else if (sz == 2'd1) begin model[b] = d[15:8]; model[b+1] = d[7:0]; end
        else begin
            model[b] = d[31:24]; model[b+1] = d[23:16];
            model[b+2] = d[15:8]; model[b+3] = d[7:0];
        end
    endtask

    task automatic do_read(input logic [31:0] a, input logic [1:0] sz, input logic sg,
                           output logic [31:0] r, output logic m);
        @(negedge clk);
        req_valid = 1'b1; wr_en = 1'b0; size = sz; addr = a; sign_ext = sg;
        @(negedge clk);
        req_valid = 1'b0;
        r = rdata;
        m = misalign;
    endtask

    task automatic read_check(input string req, input logic [31:0] a, input logic [1:0] sz,
                              input logic sg, input logic [31:0] exp);
        logic [31:0] r; logic m;
        do_read(a, sz, sg, r, m);
        check32(req, r, exp);
        check32({req, " misalign"}, {31'h0, m}, {31'h0, exp_mis(a, sz)});
    endtask

    task automatic t_reset();
        check32("R11 rdata in reset", rdata, 32'h0);
        check32("R11 misalign in reset", {31'h0, misalign}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check32("R11 rdata after reset", rdata, 32'h0);
        check32("R11 misalign after reset", {31'h0, misalign}, 32'h0);
    endtask

    task automatic t_long_layout();
        do_write(32'h100, 2'd2, 32'h11223344);
        read_check("R3 byte+0", 32'h100, 2'd0, 1'b0, 32'h11);
        read_check("R3 byte+1", 32'h101, 2'd0, 1'b0, 32'h22);
        read_check("R3 byte+2", 32'h102, 2'd0, 1'b0, 32'h33);
        read_check("R3 byte+3", 32'h103, 2'd0, 1'b0, 32'h44);
        read_check("R3 long",   32'h100, 2'd2, 1'b0, 32'h11223344);
        read_check("R4 word lo half", 32'h100, 2'd1, 1'b0, 32'h1122);
        read_check("R4 word hi half", 32'h102, 2'd1, 1'b0, 32'h3344);
    endtask

    task automatic t_partial_writes();
        do_write(32'h200, 2'd2, 32'hDEADBEEF);
        do_write(32'h204, 2'd2, 32'h01020304);
        do_write(32'h1FC, 2'd2, 32'hCAFEF00D);
        do_write(32'h202, 2'd1, 32'hFFFFA5B6);
        read_check("R4 word write order", 32'h202, 2'd0, 1'b0, 32'hA5);
        read_check("R7 word write neighbours", 32'h200, 2'd2, 1'b0, 32'hDEADA5B6);
        do_write(32'h201, 2'd0, 32'hFFFFFF7E);
        read_check("R7 byte write neighbours", 32'h200, 2'd2, 1'b0, 32'hDE7EA5B6);
        read_check("R7 next long untouched", 32'h204, 2'd2, 1'b0, 32'h01020304);
        read_check("R7 prev long untouched", 32'h1FC, 2'd2, 1'b0, 32'hCAFEF00D);
    endtask

    task automatic t_extend();
        do_write(32'h300, 2'd2, 32'h80017F80);
        read_check("R6 word signed neg",   32'h300, 2'd1, 1'b1, 32'hFFFF8001);
        read_check("R6 word unsigned",     32'h300, 2'd1, 1'b0, 32'h00008001);
        read_check("R6 word signed pos",   32'h302, 2'd1, 1'b1, 32'h00007F80);
        read_check("R5 byte signed neg",   32'h303, 2'd0, 1'b1, 32'hFFFFFF80);
        read_check("R5 byte unsigned",     32'h303, 2'd0, 1'b0, 32'h00000080);
        read_check("R5 byte signed pos",   32'h302, 2'd0, 1'b1, 32'h0000007F);
        read_check("R10 long ignores sign", 32'h300, 2'd2, 1'b1, 32'h80017F80);
    endtask

    task automatic t_align();
        read_check("R2 long at +3",  32'h103, 2'd2, 1'b0, 32'h11223344);
        read_check("R8 long at +2",  32'h102, 2'd2, 1'b0, 32'h11223344);
        read_check("R2 word at +1",  32'h101, 2'd1, 1'b0, 32'h1122);
        read_check("R2 word at +3",  32'h103, 2'd1, 1'b0, 32'h3344);
        read_check("R8 byte at +3",  32'h103, 2'd0, 1'b0, 32'h44);
        read_check("R8 aligned long", 32'h100, 2'd2, 1'b0, 32'h11223344);
        do_write(32'h407, 2'd2, 32'h55667788);
        read_check("R8 misaligned long write lands aligned", 32'h404, 2'd2, 1'b0, 32'h55667788);
    endtask

    task automatic t_size3();
        do_write(32'h501, 2'd3, 32'h0A0B0C0D);
        read_check("R10 size 3 write", 32'h500, 2'd2, 1'b0, 32'h0A0B0C0D);
        read_check("R10 size 3 read",  32'h502, 2'd3, 1'b1, 32'h0A0B0C0D);
    endtask

    task automatic t_hold();
        logic [31:0] r; logic m;
        do_write(32'h600, 2'd2, 32'h12345678);
        do_read(32'h600, 2'd2, 1'b0, r, m);
        check32("R9 one-cycle read", r, 32'h12345678);
        do_write(32'h600, 2'd2, 32'h9ABCDEF0);
        check32("R9 write leaves rdata", rdata, 32'h12345678);
        repeat (3) @(negedge clk);
        check32("R9 idle leaves rdata", rdata, 32'h12345678);
        do_read(32'h600, 2'd2, 1'b0, r, m);
        check32("R9 new read value", r, 32'h9ABCDEF0);
    endtask

    task automatic t_wrap();
        do_write(32'hABCDE0F5, 2'd0, 32'h000000C3);
        read_check("R1 high byte alias", 32'h0F5, 2'd0, 1'b0, 32'hC3);
        read_check("R1 wrapped read", 32'hFFFFF0F5, 2'd0, 1'b0, 32'hC3);
        for (int i = 0; i < MSZ / 4; i++) begin
            logic [31:0] a;
            a = ((i + 1) << P) | (i << 2);
            do_write(a, 2'd2, {i[15:0], ~i[15:0]});
        end
        for (int i = 0; i < MSZ / 4; i++) begin
            logic [31:0] r; logic m;
            do_read(32'(i << 2), 2'd2, 1'b0, r, m);
            check32("R1 exhaustive wrap", r, {i[15:0], ~i[15:0]});
        end
        read_check("R1 model agrees", 32'h7FC, 2'd2, 1'b0, exp_read(32'h7FC, 2'd2, 1'b0));
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) model[i] = 8'h00;
        t_reset();
        t_long_layout();
        t_partial_writes();
        t_extend();
        t_align();
        t_size3();
        t_hold();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule